// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block is the command front end of a parallel NOR flash model. It receives bus write cycles that have already been synchronised to the system clock. Each cycle is one pulse of `wr_valid` carrying an address and a data byte, captured from whichever of the write or chip strobes rose first. The block turns one-cycle and two-cycle command sequences into two kinds of output. The first is a persistent read-mode selection that tells the read path what to return. The second is a one-cycle operation request, with target address and data, for the erase and program engines.

The decoder tracks the lock bit of every block. It refuses erase and program requests to locked blocks unless the write-protect override input is high. It also handles the counted buffered-write sequence against a fixed buffer depth and keeps the status-pin mode. Malformed sequences and refused operations raise sticky error flags that remain set until the next read-array command. While an operation is running, only a small set of commands is accepted.

Top module: `flashcmd_decoder`

## Requirements
- R1: After reset, `rd_mode` is 0 (array), `op_valid`, `seq_err`, `prot_err` and `sts_mode` are 0, and no block is locked.
- R2: In idle with `busy` low, a write of FFh selects read mode 0 and clears both `seq_err` and `prot_err`.
- R3: In idle, 90h selects read mode 1 (identifier), 98h selects mode 2 (query), and 70h selects mode 3 (status). Every other first cycle, whether a valid command or an error, selects mode 3.
- R4: 40h or 10h, followed by a write at address A with data D, issues `op_code` 2 (program) with `op_addr`=A and `op_data`=D. `op_valid` is high for exactly the one clock cycle after the second write.
- R5: 20h followed by D0h at address A issues `op_code` 1 (erase) with `op_addr`=A.
- R6: E8h at address S, then a count byte C, gives N=C+1. The next N writes each issue `op_code` 3 (buffer load) with their own address and data. A following D0h issues `op_code` 4 (buffered program) with `op_addr`=S and `op_data`=C.
- R7: A buffered-write count byte of BUF_DEPTH or more sets `seq_err`, returns the decoder to idle and issues no operation.
- R8: In idle, B0h issues `op_code` 5 (suspend) and D0h issues `op_code` 6 (resume).
- R9: 60h then 01h issues `op_code` 7 and locks the block given by the top log2(NUM_BLOCKS) address bits, whatever the state of `wp_en`. 60h then D0h with `wp_en` high issues `op_code` 8 and unlocks all blocks at once.
- R10: B8h followed by a mode byte M from 0 to 3 sets `sts_mode`=M and issues `op_code` 9 with `op_data`=M. Any larger M sets `seq_err` and leaves `sts_mode` unchanged.
- R11: With `wp_en` low, the following issue no operation and set `prot_err`: a program or erase to a locked block, a buffered program whose start address is in a locked block, and a lock clear.
- R12: A reserved first byte, or a wrong confirm or mode byte in the second cycle, sets `seq_err`, issues no operation and returns the decoder to idle.
- R13: While `busy` is high in idle, only B0h and 70h are accepted. Any other write is ignored, leaves `rd_mode` unchanged and sets `seq_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One-cycle pulse per captured bus write |
| wr_addr | input | ADDR_W | Address of the write cycle |
| wr_data | input | 8 | Data byte of the write cycle |
| wp_en | input | 1 | High permits erase or program of locked blocks and lock clearing |
| busy | input | 1 | An erase or program is in progress |
| rd_mode | output | 2 | Read selection: 0 array, 1 identifier, 2 query, 3 status |
| op_valid | output | 1 | One-cycle operation request strobe |
| op_code | output | 4 | Operation code as listed in the requirements |
| op_addr | output | ADDR_W | Target address of the request |
| op_data | output | 8 | Data, count or mode byte of the request |
| seq_err | output | 1 | Sticky command-sequence error |
| prot_err | output | 1 | Sticky protection refusal |
| sts_mode | output | 2 | Status-pin mode: 0 level, 1 erase pulse, 2 write pulse, 3 both |

## Verification
The hardest state to reach is the confirm step of a buffered write at every legal count. It needs an exact run of count plus one data cycles, and an off-by-one in the down-counter only shows up at the extremes of the range. The bench therefore drives every count from 1 to BUF_DEPTH and checks each load strobe and the final request, then drives the first illegal count. A second hard case combines lock state with the write-protect input. Locks are set on alternating blocks, and program attempts are then swept across all blocks with the override low and high, both before and after a refused clear and a granted clear.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_IDENT  = 2'd1,
        RD_QUERY  = 2'd2,
        RD_STATUS = 2'd3
    } rd_mode_e;

    typedef enum logic [3:0] {
        OP_NONE     = 4'd0,
        OP_ERASE    = 4'd1,
        OP_PROG     = 4'd2,
        OP_BUF_LOAD = 4'd3,
        OP_BUF_PROG = 4'd4,
        OP_SUSPEND  = 4'd5,
        OP_RESUME   = 4'd6,
        OP_LOCK_SET = 4'd7,
        OP_LOCK_CLR = 4'd8,
        OP_STS_CFG  = 4'd9
    } op_e;

    typedef enum logic [3:0] {
        CL_RESERVED,
        CL_ARRAY,
        CL_IDENT,
        CL_QUERY,
        CL_STATUS,
        CL_PROG,
        CL_ERASE,
        CL_BUF,
        CL_SUSPEND,
        CL_CONFIRM,
        CL_LOCK,
        CL_CFG
    } cls_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PROG,
        S_ERASE,
        S_BUF_CNT,
        S_BUF_DATA,
        S_BUF_CONF,
        S_LOCK,
        S_CFG
    } state_e;

    localparam logic [7:0] CODE_CONFIRM  = 8'hD0;
    localparam logic [7:0] CODE_LOCK_ON  = 8'h01;
    localparam logic [7:0] CODE_MODE_MAX = 8'h03;

endpackage

// File: rtl/flashcmd_opclass.sv
module flashcmd_opclass
    import flashcmd_pkg::*;
(
    input  logic [7:0] code,
    output cls_e       cls
);

    always_comb begin
        unique case (code)
            8'hFF:        cls = CL_ARRAY;
            8'h90:        cls = CL_IDENT;
            8'h98:        cls = CL_QUERY;
            8'h70:        cls = CL_STATUS;
            8'h40, 8'h10: cls = CL_PROG;
            8'h20:        cls = CL_ERASE;
            8'hE8:        cls = CL_BUF;
            8'hB0:        cls = CL_SUSPEND;
            8'hD0:        cls = CL_CONFIRM;
            8'h60:        cls = CL_LOCK;
            8'hB8:        cls = CL_CFG;
            default:      cls = CL_RESERVED;
        endcase
    end

endmodule

// File: rtl/flashcmd_lockbank.sv
module flashcmd_lockbank #(
    parameter int NUM_BLOCKS = 8,
    localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_en,
    input  logic [BLK_W-1:0]      set_idx,
    input  logic                  clr_all,
    output logic [NUM_BLOCKS-1:0] locked
);

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        logic lock_d, lock_q;

        always_comb begin
            lock_d = lock_q;
            if (clr_all) begin
                lock_d = 1'b0;
            end else if (set_en && set_idx == BLK_W'(b)) begin
                lock_d = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lock_q <= 1'b0;
            end else begin
                lock_q <= lock_d;
            end
        end

        assign locked[b] = lock_q;
    end

    assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (locked == '0));

    assert_set_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_all) |=> locked[$past(set_idx)]);

endmodule

// File: rtl/flashcmd_seq.sv
module flashcmd_seq
    import flashcmd_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_BLOCKS = 8,
    parameter int BUF_DEPTH  = 32,
    localparam int BLK_W = $clog2(NUM_BLOCKS),
    localparam int CNT_W = $clog2(BUF_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_valid,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  wp_en,
    input  logic                  busy,
    input  cls_e                  cls,
    input  logic [NUM_BLOCKS-1:0] locked,
    output logic                  lock_set,
    output logic                  lock_clr,
    output logic [BLK_W-1:0]      lock_idx,
    output rd_mode_e              rd_mode,
    output logic                  op_valid,
    output op_e                   op_code,
    output logic [ADDR_W-1:0]     op_addr,
    output logic [7:0]            op_data,
    output logic                  seq_err,
    output logic                  prot_err,
    output logic [1:0]            sts_mode
);

    typedef struct packed {
        state_e              state;
        rd_mode_e            rd_mode;
        logic                op_valid;
        op_e                 op_code;
        logic [ADDR_W-1:0]   op_addr;
        logic [7:0]          op_data;
        logic                seq_err;
        logic                prot_err;
        logic [1:0]          sts_mode;
        logic [CNT_W-1:0]    cnt;
        logic [7:0]          buf_n;
        logic [ADDR_W-1:0]   start_addr;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [BLK_W-1:0] wr_blk, start_blk;
    logic             wr_blocked, start_blocked;

    assign wr_blk        = wr_addr[ADDR_W-1 -: BLK_W];
    assign start_blk     = r_q.start_addr[ADDR_W-1 -: BLK_W];
    assign wr_blocked    = locked[wr_blk] && !wp_en;
    assign start_blocked = locked[start_blk] && !wp_en;
    assign lock_idx      = wr_blk;

    always_comb begin
        r_d          = r_q;
        r_d.op_valid = 1'b0;
        r_d.op_code  = OP_NONE;
        lock_set     = 1'b0;
        lock_clr     = 1'b0;

        if (wr_valid) begin
            unique case (r_q.state)
                S_IDLE: begin
                    if (busy && !(cls == CL_SUSPEND || cls == CL_STATUS)) begin
                        r_d.seq_err = 1'b1;
                    end else begin
                        r_d.rd_mode = RD_STATUS;
                        unique case (cls)
                            CL_ARRAY: begin
                                r_d.rd_mode  = RD_ARRAY;
                                r_d.seq_err  = 1'b0;
                                r_d.prot_err = 1'b0;
                            end
                            CL_IDENT:  r_d.rd_mode = RD_IDENT;
                            CL_QUERY:  r_d.rd_mode = RD_QUERY;
                            CL_STATUS: r_d.rd_mode = RD_STATUS;
                            CL_PROG:   r_d.state = S_PROG;
                            CL_ERASE:  r_d.state = S_ERASE;
                            CL_BUF: begin
                                r_d.state      = S_BUF_CNT;
                                r_d.start_addr = wr_addr;
                            end
                            CL_LOCK: r_d.state = S_LOCK;
                            CL_CFG:  r_d.state = S_CFG;
                            CL_SUSPEND: begin
                                r_d.op_valid = 1'b1;
                                r_d.op_code  = OP_SUSPEND;
                                r_d.op_addr  = wr_addr;
                                r_d.op_data  = wr_data;
                            end
                            CL_CONFIRM: begin
                                r_d.op_valid = 1'b1;
                                r_d.op_code  = OP_RESUME;
                                r_d.op_addr  = wr_addr;
                                r_d.op_data  = wr_data;
                            end
                            default: r_d.seq_err = 1'b1;
                        endcase
                    end
                end

                S_PROG: begin
                    r_d.state = S_IDLE;
                    if (wr_blocked) begin
                        r_d.prot_err = 1'b1;
                    end else begin
                        r_d.op_valid = 1'b1;
                        r_d.op_code  = OP_PROG;
                        r_d.op_addr  = wr_addr;
                        r_d.op_data  = wr_data;
                    end
                end

                S_ERASE: begin
                    r_d.state = S_IDLE;
                    if (wr_data != CODE_CONFIRM) begin
                        r_d.seq_err = 1'b1;
                    end else if (wr_blocked) begin
                        r_d.prot_err = 1'b1;
                    end else begin
                        r_d.op_valid = 1'b1;
                        r_d.op_code  = OP_ERASE;
                        r_d.op_addr  = wr_addr;
                        r_d.op_data  = wr_data;
                    end
                end

                S_BUF_CNT: begin
                    if ({24'd0, wr_data} >= BUF_DEPTH) begin
                        r_d.state   = S_IDLE;
                        r_d.seq_err = 1'b1;
                    end else begin
                        r_d.state = S_BUF_DATA;
                        r_d.buf_n = wr_data;
                        r_d.cnt   = CNT_W'(wr_data) + CNT_W'(1);
                    end
                end

                S_BUF_DATA: begin
                    r_d.op_valid = 1'b1;
                    r_d.op_code  = OP_BUF_LOAD;
                    r_d.op_addr  = wr_addr;
                    r_d.op_data  = wr_data;
                    r_d.cnt      = r_q.cnt - CNT_W'(1);
                    if (r_q.cnt == CNT_W'(1)) begin
                        r_d.state = S_BUF_CONF;
                    end
                end

                S_BUF_CONF: begin
                    r_d.state = S_IDLE;
                    if (wr_data != CODE_CONFIRM) begin
                        r_d.seq_err = 1'b1;
                    end else if (start_blocked) begin
                        r_d.prot_err = 1'b1;
                    end else begin
                        r_d.op_valid = 1'b1;
                        r_d.op_code  = OP_BUF_PROG;
                        r_d.op_addr  = r_q.start_addr;
                        r_d.op_data  = r_q.buf_n;
                    end
                end

                S_LOCK: begin
                    r_d.state = S_IDLE;
                    if (wr_data == CODE_LOCK_ON) begin
                        r_d.op_valid = 1'b1;
                        r_d.op_code  = OP_LOCK_SET;
                        r_d.op_addr  = wr_addr;
                        r_d.op_data  = wr_data;
                        lock_set     = 1'b1;
                    end else if (wr_data == CODE_CONFIRM) begin
                        if (!wp_en) begin
                            r_d.prot_err = 1'b1;
                        end else begin
                            r_d.op_valid = 1'b1;
                            r_d.op_code  = OP_LOCK_CLR;
                            r_d.op_addr  = wr_addr;
                            r_d.op_data  = wr_data;
                            lock_clr     = 1'b1;
                        end
                    end else begin
                        r_d.seq_err = 1'b1;
                    end
                end

                S_CFG: begin
                    r_d.state = S_IDLE;
                    if (wr_data <= CODE_MODE_MAX) begin
                        r_d.sts_mode = wr_data[1:0];
                        r_d.op_valid = 1'b1;
                        r_d.op_code  = OP_STS_CFG;
                        r_d.op_addr  = wr_addr;
                        r_d.op_data  = wr_data;
                    end else begin
                        r_d.seq_err = 1'b1;
                    end
                end

                default: r_d.state = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_mode  = r_q.rd_mode;
    assign op_valid = r_q.op_valid;
    assign op_code  = r_q.op_code;
    assign op_addr  = r_q.op_addr;
    assign op_data  = r_q.op_data;
    assign seq_err  = r_q.seq_err;
    assign prot_err = r_q.prot_err;
    assign sts_mode = r_q.sts_mode;

    assert_op_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(wr_valid));

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CNT_W'(BUF_DEPTH));

    assert_read_array_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && r_q.state == S_IDLE && !busy && wr_data == 8'hFF)
        |=> (rd_mode == RD_ARRAY && !seq_err && !prot_err));

    assert_clear_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && r_q.state == S_LOCK && wr_data == CODE_CONFIRM && !wp_en)
        |=> (!op_valid && prot_err));

    assert_busy_gate_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && busy && r_q.state == S_IDLE)
        |=> (!op_valid || op_code == OP_SUSPEND));

endmodule

// File: rtl/flashcmd_decoder.sv
module flashcmd_decoder #(
    parameter int ADDR_W     = 12,
    parameter int NUM_BLOCKS = 8,
    parameter int BUF_DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              wp_en,
    input  logic              busy,
    output logic [1:0]        rd_mode,
    output logic              op_valid,
    output logic [3:0]        op_code,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic              seq_err,
    output logic              prot_err,
    output logic [1:0]        sts_mode
);
    import flashcmd_pkg::*;

    localparam int BLK_W = $clog2(NUM_BLOCKS);

    cls_e                  cls;
    logic [NUM_BLOCKS-1:0] locked;
    logic                  lock_set, lock_clr;
    logic [BLK_W-1:0]      lock_idx;
    rd_mode_e              rd_mode_w;
    op_e                   op_code_w;

    flashcmd_opclass u_opclass (
        .code (wr_data),
        .cls  (cls)
    );

    flashcmd_lockbank #(
        .NUM_BLOCKS (NUM_BLOCKS)
    ) u_lockbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (lock_set),
        .set_idx (lock_idx),
        .clr_all (lock_clr),
        .locked  (locked)
    );

    flashcmd_seq #(
        .ADDR_W     (ADDR_W),
        .NUM_BLOCKS (NUM_BLOCKS),
        .BUF_DEPTH  (BUF_DEPTH)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wp_en    (wp_en),
        .busy     (busy),
        .cls      (cls),
        .locked   (locked),
        .lock_set (lock_set),
        .lock_clr (lock_clr),
        .lock_idx (lock_idx),
        .rd_mode  (rd_mode_w),
        .op_valid (op_valid),
        .op_code  (op_code_w),
        .op_addr  (op_addr),
        .op_data  (op_data),
        .seq_err  (seq_err),
        .prot_err (prot_err),
        .sts_mode (sts_mode)
    );

    assign rd_mode = rd_mode_w;
    assign op_code = op_code_w;

endmodule

// File: tb/flashcmd_decoder_tb.sv
`timescale 1ns/1ps
module flashcmd_decoder_tb;

    localparam int ADDR_W = 12;
    localparam int DEPTH  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              wp_en = 1'b0;
    logic              busy = 1'b0;
    logic [1:0]        rd_mode;
    logic              op_valid;
    logic [3:0]        op_code;
    logic [ADDR_W-1:0] op_addr;
    logic [7:0]        op_data;
    logic              seq_err, prot_err;
    logic [1:0]        sts_mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    flashcmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wp_en(wp_en), .busy(busy), .rd_mode(rd_mode),
        .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr),
        .op_data(op_data), .seq_err(seq_err), .prot_err(prot_err),
        .sts_mode(sts_mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic expect_op(input string req, input logic v, input logic [3:0] code,
                             input logic [ADDR_W-1:0] a, input logic [7:0] d);
        chk({req, " op_valid"}, op_valid, v);
        if (v) begin
            chk({req, " op_code"}, op_code, code);
            chk({req, " op_addr"}, op_addr, a);
            chk({req, " op_data"}, op_data, d);
        end
    endtask

    function automatic logic [1:0] first_mode(input logic [7:0] b);
        case (b)
            8'hFF:   return 2'd0;
            8'h90:   return 2'd1;
            8'h98:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic bit is_reserved(input logic [7:0] b);
        case (b)
            8'hFF, 8'h90, 8'h98, 8'h70, 8'h40, 8'h10, 8'h20,
            8'hE8, 8'hB0, 8'hD0, 8'h60, 8'hB8: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] blk_addr(input int blk, input int off);
        return ADDR_W'((blk << (ADDR_W - 3)) | off);
    endfunction

    task automatic prog_try(input string req, input int blk, input bit expect_ok);
        wr(blk_addr(blk, 4), 8'h40);
        wr(blk_addr(blk, 5), 8'h3C);
        expect_op(req, expect_ok, 4'd2, blk_addr(blk, 5), 8'h3C);
        chk({req, " prot_err"}, prot_err, !expect_ok);
        wr('0, 8'hFF);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [1:0] last_mode;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rd_mode", rd_mode, 2'd0);
        chk("R1 op_valid", op_valid, 1'b0);
        chk("R1 seq_err", seq_err, 1'b0);
        chk("R1 prot_err", prot_err, 1'b0);
        chk("R1 sts_mode", sts_mode, 2'd0);
        prog_try("R1 unlocked at reset", 5, 1'b1);

        // Sweep every first byte in idle (R3, R8, R12), with a follow-up byte 55h (R4, R7, R12)
        for (int b = 0; b < 256; b++) begin
            wr(12'h0A5, 8'(b));
            chk("R3 first-cycle mode", rd_mode, first_mode(8'(b)));
            chk("R12 reserved flag", seq_err, is_reserved(8'(b)));
            if (b == 8'hB0)      expect_op("R8 suspend", 1'b1, 4'd5, 12'h0A5, 8'hB0);
            else if (b == 8'hD0) expect_op("R8 resume", 1'b1, 4'd6, 12'h0A5, 8'hD0);
            else                 chk("R12 no op on first cycle", op_valid, 1'b0);
            if (b == 8'h40 || b == 8'h10) begin
                wr(12'h0A6, 8'h55);
                expect_op("R4 program", 1'b1, 4'd2, 12'h0A6, 8'h55);
                chk("R4 no error", seq_err, 1'b0);
                @(negedge clk);
                chk("R4 single-cycle strobe", op_valid, 1'b0);
            end else if (b == 8'h20 || b == 8'hE8 || b == 8'h60 || b == 8'hB8) begin
                wr(12'h0A6, 8'h55);
                chk("R12 bad second cycle flag", seq_err, 1'b1);
                chk("R12 bad second cycle no op", op_valid, 1'b0);
                chk("R12 status after error", rd_mode, 2'd3);
            end
            wr('0, 8'hFF);
            chk("R2 array mode", rd_mode, 2'd0);
            chk("R2 error cleared", seq_err, 1'b0);
        end

        // R10 status-pin mode sweep
        last_mode = 2'd0;
        for (int m = 0; m < 256; m++) begin
            wr(12'h011, 8'hB8);
            wr(12'h012, 8'(m));
            if (m < 4) begin
                last_mode = 2'(m);
                expect_op("R10 config", 1'b1, 4'd9, 12'h012, 8'(m));
            end else begin
                chk("R10 bad mode flag", seq_err, 1'b1);
                chk("R10 bad mode no op", op_valid, 1'b0);
            end
            chk("R10 sts_mode", sts_mode, last_mode);
            wr('0, 8'hFF);
        end

        // R6 and R7 buffered write over all counts and one past the depth
        for (int n = 1; n <= DEPTH + 1; n++) begin
            wr(12'h123, 8'hE8);
            wr(12'h123, 8'(n - 1));
            if (n > DEPTH) begin
                chk("R7 over-depth flag", seq_err, 1'b1);
                chk("R7 over-depth no op", op_valid, 1'b0);
                wr(12'h200, 8'h40);
                chk("R7 back in idle", op_valid, 1'b0);
                wr('0, 8'hFF);
                wr('0, 8'hFF);
            end else begin
                for (int i = 0; i < n; i++) begin
                    wr(ADDR_W'(12'h200 + i), 8'(i ^ n));
                    expect_op("R6 buffer load", 1'b1, 4'd3, ADDR_W'(12'h200 + i), 8'(i ^ n));
                end
                wr(12'h7FF, 8'hD0);
                expect_op("R6 buffered program", 1'b1, 4'd4, 12'h123, 8'(n - 1));
                chk("R6 no error", seq_err, 1'b0);
                wr('0, 8'hFF);
            end
        end

        // R5 erase
        wr(12'h456, 8'h20);
        wr(12'h457, 8'hD0);
        expect_op("R5 erase", 1'b1, 4'd1, 12'h457, 8'hD0);
        wr('0, 8'hFF);

        // R9 lock set on even blocks with wp_en low; R11 sweep
        wp_en = 1'b0;
        for (int k = 0; k < 8; k += 2) begin
            wr(blk_addr(k, 9), 8'h60);
            wr(blk_addr(k, 9), 8'h01);
            expect_op("R9 lock set", 1'b1, 4'd7, blk_addr(k, 9), 8'h01);
            wr('0, 8'hFF);
        end
        for (int k = 0; k < 8; k++) prog_try("R11 program gated", k, (k % 2) == 1);
        wp_en = 1'b1;
        for (int k = 0; k < 8; k++) prog_try("R11 override", k, 1'b1);
        wp_en = 1'b0;
        wr(blk_addr(2, 1), 8'h20);
        wr(blk_addr(2, 1), 8'hD0);
        expect_op("R11 erase locked", 1'b0, 4'd0, '0, '0);
        chk("R11 erase prot_err", prot_err, 1'b1);
        wr('0, 8'hFF);
        wr(blk_addr(4, 0), 8'hE8);
        wr(blk_addr(4, 0), 8'h00);
        wr(blk_addr(1, 0), 8'h77);
        wr(blk_addr(1, 0), 8'hD0);
        expect_op("R11 buffered locked", 1'b0, 4'd0, '0, '0);
        chk("R11 buffered prot_err", prot_err, 1'b1);
        wr('0, 8'hFF);
        wr('0, 8'h60);
        wr('0, 8'hD0);
        expect_op("R11 clear refused", 1'b0, 4'd0, '0, '0);
        chk("R11 clear prot_err", prot_err, 1'b1);
        wr('0, 8'hFF);
        prog_try("R11 still locked after refused clear", 6, 1'b0);
        wp_en = 1'b1;
        wr(12'h001, 8'h60);
        wr(12'h001, 8'hD0);
        expect_op("R9 lock clear", 1'b1, 4'd8, 12'h001, 8'hD0);
        wr('0, 8'hFF);
        wp_en = 1'b0;
        for (int k = 0; k < 8; k++) prog_try("R9 all cleared", k, 1'b1);

        // R13 busy gating
        busy = 1'b1;
        wr('0, 8'h90);
        chk("R13 ignored mode", rd_mode, 2'd0);
        chk("R13 ignored flag", seq_err, 1'b1);
        chk("R13 ignored no op", op_valid, 1'b0);
        wr('0, 8'h40);
        wr(12'h0C0, 8'h12);
        chk("R13 program ignored", op_valid, 1'b0);
        chk("R13 mode unchanged", rd_mode, 2'd0);
        wr(12'h0B0, 8'hB0);
        expect_op("R13 suspend accepted", 1'b1, 4'd5, 12'h0B0, 8'hB0);
        wr('0, 8'h70);
        chk("R13 status accepted", rd_mode, 2'd3);
        busy = 1'b0;
        wr(12'h0D0, 8'hD0);
        expect_op("R8 resume after suspend", 1'b1, 4'd6, 12'h0D0, 8'hD0);
        wr('0, 8'hFF);
        chk("R2 clears after busy", seq_err, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule